// File: doc/BRIEF.md
# Programmable Timer Counter Channel

A single 16-bit down-counting timer channel with two behaviours picked by a control write: an event counter whose output rises when the count runs out, and a hardware one-shot that a rising gate edge fires and can fire again. Software writes a control word to select the behaviour, then writes a 16-bit count as two bytes, low byte first. A holding register keeps the written count, and a separate working counter does the decrementing.

The whole channel sits in one system clock domain. Each falling edge of the external count clock reaches the block as a one-cycle `tick` pulse. The gate pin is sampled on every system clock. In event-counter mode it enables or freezes counting. In one-shot mode its rising edges are held until the next tick takes them. The output pin is registered.

Top module: `tmr_channel`

## Requirements
- R1: After reset the output is low and the channel is in event-counter mode (`ctl_mode`=0). A control write with `ctl_mode`=0 drives the output low in the following cycle.
- R2: In event-counter mode, the first tick after the high-byte write copies the count into the working counter without decrementing. A tick in the same cycle as that write does not count. With gate high and count N, the output goes high on the (N+1)th tick after the write.
- R3: In event-counter mode, gate low stops decrementing but still lets the load tick happen. If the count was loaded while gate was low, the output rises on the Nth tick after gate goes high. Gate changes never alter the output in this mode.
- R4: In event-counter mode, a low-byte write stops counting and drives the output low in the following cycle, with no tick needed. Ticks seen before the high byte arrives change nothing. After the high byte, N+1 ticks are again needed.
- R5: In event-counter mode, a new count written while counting is running is loaded on the next tick, and counting continues from the new value.
- R6: A control write with `ctl_mode`=1 (one-shot) drives the output high in the following cycle.
- R7: In one-shot mode, a gate rising edge is held until the next tick. That tick loads the count and drives the output low; a tick in the same cycle as the edge also counts. The output returns high on the Nth tick after the trigger tick.
- R8: In one-shot mode, taking the gate low during a pulse does not affect the output. A new rising edge reloads the full count, so the pulse lasts N ticks from the retrigger.
- R9: In one-shot mode, a count written during a pulse leaves that pulse unchanged. The new count is used from the next trigger on.
- R10: A count of 0 acts as 65536. In event-counter mode the output rises on the 65537th tick after the write.
- R11: In one-shot mode, the output stays high after a pulse ends, and no further pulse starts without a new gate rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_mode | input | 1 | Mode with the control write: 0 event counter, 1 one-shot |
| cnt_we | input | 1 | Count byte write strobe (low byte, then high byte) |
| cnt_byte | input | 8 | Count byte data |
| tick | input | 1 | One-cycle pulse per count clock falling edge |
| gate | input | 1 | Gate pin |
| tout | output | 1 | Timer output pin |

## Verification
Two pairs of events can land in the same system clock cycle, and each pair is provoked on purpose. First, a high-byte count write is driven in the same cycle as a tick in event-counter mode. The bench then expects N+1 further ticks before the output rises, because the coincident tick must not load the count. Second, a gate rising edge is driven in the same cycle as a tick in one-shot mode. The bench expects the output low right after that tick, because the edge must trigger on that tick and not on the next one.

// File: rtl/tmr_channel.sv
module tmr_channel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_mode,
  input  logic       cnt_we,
  input  logic [7:0] cnt_byte,
  input  logic       tick,
  input  logic       gate,
  output logic       tout
);
  localparam int CW = 16;

  logic          mode_r, hi_sel, load_pend, running, cr_valid, trig_pend, gate_q;
  logic [7:0]    lo_r;
  logic [CW-1:0] cr, ce;

  wire gate_rise = gate & ~gate_q;
  wire lo_wr     = cnt_we & ~hi_sel & ~ctl_we;
  wire hi_wr     = cnt_we &  hi_sel & ~ctl_we;
  wire trig      = trig_pend | gate_rise;
  wire m0_hold   = hi_sel | lo_wr;
  wire ce_last   = (ce == CW'(1));
  wire [CW-1:0] ce_dec = ce - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r    <= 1'b0;
      tout      <= 1'b0;
      hi_sel    <= 1'b0;
      load_pend <= 1'b0;
      running   <= 1'b0;
      cr_valid  <= 1'b0;
      trig_pend <= 1'b0;
      gate_q    <= 1'b0;
      lo_r      <= '0;
      cr        <= '0;
      ce        <= '0;
    end else begin
      gate_q <= gate;
      if (ctl_we) begin
        mode_r    <= ctl_mode;
        tout      <= ctl_mode;
        hi_sel    <= 1'b0;
        load_pend <= 1'b0;
        running   <= 1'b0;
        cr_valid  <= 1'b0;
        trig_pend <= 1'b0;
      end else begin
        if (cnt_we) hi_sel <= ~hi_sel;
        if (lo_wr)  lo_r   <= cnt_byte;
        if (hi_wr) begin
          cr       <= {cnt_byte, lo_r};
          cr_valid <= 1'b1;
        end
        if (!mode_r) begin
          if (lo_wr) begin
            tout      <= 1'b0;
            load_pend <= 1'b0;
          end
          if (hi_wr) load_pend <= 1'b1;
          if (tick && !m0_hold) begin
            if (load_pend) begin
              ce        <= cr;
              running   <= 1'b1;
              load_pend <= 1'b0;
            end else if (running && gate) begin
              ce <= ce_dec;
              if (ce_last) tout <= 1'b1;
            end
          end
        end else begin
          if (tick) begin
            trig_pend <= 1'b0;
            if (trig && cr_valid) begin
              ce      <= cr;
              running <= 1'b1;
              tout    <= 1'b0;
            end else if (running) begin
              ce <= ce_dec;
              if (ce_last) begin
                tout    <= 1'b1;
                running <= 1'b0;
              end
            end
          end else if (gate_rise) begin
            trig_pend <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module tmr_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_we,
  input logic ctl_mode,
  input logic cnt_we,
  input logic tick,
  input logic tout,
  input logic mode_r,
  input logic hi_sel
);
  AST_M0_CTL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !ctl_mode |=> !tout); // R1
  AST_M1_CTL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_mode |=> tout); // R6
  AST_M0_LO_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && cnt_we && !mode_r && !hi_sel |=> !tout); // R4
  AST_M0_GATE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && !cnt_we && !mode_r && tout |=> tout); // R3
  AST_M0_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && !mode_r && !tick && !tout |=> !tout); // R2
  AST_M1_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && mode_r && !tick |=> $stable(tout)); // R7
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode(ctl_mode),
  .cnt_we(cnt_we), .tick(tick), .tout(tout), .mode_r(mode_r), .hi_sel(hi_sel)
);

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_mode = 1'b0, cnt_we = 1'b0, tick = 1'b0, gate = 1'b0;
  logic [7:0] cnt_byte = 8'h00;
  logic tout;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_channel dut (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode(ctl_mode),
    .cnt_we(cnt_we), .cnt_byte(cnt_byte), .tick(tick), .gate(gate), .tout(tout));

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (tout !== exp) begin
      errs++;
      $display("FAIL %s: tout=%0b expected %0b", tag, tout, exp);
    end
  endtask

  task automatic ctl(input logic m);
    ctl_we = 1'b1; ctl_mode = m; @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wr(input logic [7:0] b);
    cnt_we = 1'b1; cnt_byte = b; @(negedge clk); cnt_we = 1'b0;
  endtask
  task automatic wr16(input logic [15:0] v);
    wr(v[7:0]); wr(v[15:8]);
  endtask
  task automatic tk();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask
  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk(1'b0, "R1 reset state");

    // Event counter sweep, gate high
    gate = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      ctl(1'b0);
      chk(1'b0, $sformatf("R1 control write N=%0d", n));
      wr16(16'(n));
      for (int k = 1; k <= n + 2; k++) begin
        tk();
        chk(k >= n + 1, $sformatf("R2 N=%0d tick %0d", n, k));
      end
    end

    // High byte write coincident with a tick: that tick must not load
    ctl(1'b0);
    wr(8'd3);
    cnt_we = 1'b1; cnt_byte = 8'd0; tick = 1'b1; @(negedge clk);
    cnt_we = 1'b0; tick = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      tk();
      chk(k >= 4, $sformatf("R2 coincident write tick %0d", k));
    end

    // Low byte suspends and forces low
    ctl(1'b0);
    wr16(16'd2);
    repeat (3) tk();
    chk(1'b1, "R4 terminal before rewrite");
    wr(8'd3);
    chk(1'b0, "R4 low byte forces low");
    repeat (4) tk();
    chk(1'b0, "R4 suspended ticks");
    wr(8'd0);
    for (int k = 1; k <= 4; k++) begin
      tk();
      chk(k >= 4, $sformatf("R4 after high byte tick %0d", k));
    end

    // Rewrite during counting
    ctl(1'b0);
    wr16(16'd10);
    repeat (3) tk();
    wr16(16'd2);
    for (int k = 1; k <= 3; k++) begin
      tk();
      chk(k >= 3, $sformatf("R5 new count tick %0d", k));
    end

    // Gate low during load and count
    ctl(1'b0);
    gate = 1'b0;
    wr16(16'd3);
    tk();
    repeat (5) tk();
    chk(1'b0, "R3 frozen with gate low");
    gate = 1'b1;
    idle();
    chk(1'b0, "R3 gate rise no output change");
    for (int k = 1; k <= 3; k++) begin
      tk();
      chk(k >= 3, $sformatf("R3 gate enabled tick %0d", k));
    end
    gate = 1'b0; idle(); idle();
    chk(1'b1, "R3 gate fall keeps output");

    // Count zero = 65536
    ctl(1'b0);
    gate = 1'b1;
    wr16(16'd0);
    tick = 1'b1;
    repeat (65536) @(negedge clk);
    tick = 1'b0;
    chk(1'b0, "R10 after 65536 ticks");
    tk();
    chk(1'b1, "R10 after 65537 ticks");

    // One-shot sweep
    gate = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      ctl(1'b1);
      chk(1'b1, $sformatf("R6 control write N=%0d", n));
      wr16(16'(n));
      tk(); tk();
      chk(1'b1, $sformatf("R11 no trigger N=%0d", n));
      gate = 1'b1; idle();
      for (int k = 1; k <= n + 2; k++) begin
        tk();
        chk(k >= n + 1, $sformatf("R7 N=%0d tick %0d", n, k));
      end
      gate = 1'b0; idle();
      repeat (n + 2) tk();
      chk(1'b1, $sformatf("R11 no repeat N=%0d", n));
    end

    // Gate rise coincident with tick
    ctl(1'b1);
    wr16(16'd2);
    gate = 1'b1; tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk(1'b0, "R7 coincident trigger");
    tk(); chk(1'b0, "R7 coincident tick 2");
    tk(); chk(1'b1, "R7 coincident end");
    gate = 1'b0; idle();

    // Retrigger
    ctl(1'b1);
    wr16(16'd4);
    gate = 1'b1; idle();
    tk(); tk();
    gate = 1'b0; idle();
    chk(1'b0, "R8 gate fall no effect");
    gate = 1'b1; idle();
    for (int k = 1; k <= 5; k++) begin
      tk();
      chk(k >= 5, $sformatf("R8 retrigger tick %0d", k));
    end
    gate = 1'b0; idle();

    // Count write during pulse
    ctl(1'b1);
    wr16(16'd3);
    gate = 1'b1; idle();
    tk();
    wr16(16'd6);
    for (int k = 2; k <= 4; k++) begin
      tk();
      chk(k >= 4, $sformatf("R9 old pulse tick %0d", k));
    end
    gate = 1'b0; idle();
    gate = 1'b1; idle();
    for (int k = 1; k <= 7; k++) begin
      tk();
      chk(k >= 7, $sformatf("R9 new count tick %0d", k));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule